// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns an asynchronous serial input line into characters. A line-control word sets the character format: five to eight data bits, no parity or even, odd or fixed (stick) parity, and any stop-bit count on the sending side. The line is sampled on a shared enable pulse that runs at sixteen times the baud rate. A falling edge is confirmed as a start bit halfway through the bit. Each following bit is sampled at its centre, least significant data bit first. After the first stop bit is sampled, the character is written into a receive buffer. The parity, framing and break flags are stored with it.

The buffer works in one of two ways. In character mode it holds a single entry. In queued mode it is a first-in first-out store of `DEPTH` entries. The oldest entry is always visible on the read port, and a one-cycle read strobe removes it. If a character arrives while the buffer is full, it is dropped and a sticky overrun flag is raised. The baud-rate generator is outside the block, and its output reaches the block as the tick input.

Top module: `uart_frame_rx`

## Requirements
- R1: `cfg_wlen` selects the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits are received least significant first. The stored byte keeps the received bits in its low positions and has zeros above them.
- R2: A falling edge on `rxd` starts a frame only if the line is still low at the eighth tick after the edge. A low pulse shorter than that is ignored and stores nothing.
- R3: With parity enabled and stick parity off, `cfg_par_even`=1 requires an even total of ones over the data and parity bits, and `cfg_par_even`=0 requires an odd total. A mismatch sets the stored parity-error flag.
- R4: With parity enabled and `cfg_par_stick`=1, the parity bit must be 0 when `cfg_par_even`=1 and must be 1 when `cfg_par_even`=0. Any other value sets the parity-error flag.
- R5: With parity disabled, no parity bit is expected, and the parity-error flag is always 0.
- R6: The framing-error flag is set when the first stop bit is sampled low. No later stop bit is examined, so a new start bit may follow the first stop bit directly.
- R7: The break flag is set when all data bits, the parity bit (if enabled) and the first stop bit are sampled low. A break also sets the framing-error flag. A line that stays low after a break produces no further characters.
- R8: With `cfg_fifo_en`=0, the buffer holds one entry. With `cfg_fifo_en`=1, it holds `DEPTH` entries, which are read out in arrival order through `rd_valid`, the entry fields and `rd_en`.
- R9: A character that completes while the buffer is full is discarded and sets `overrun`. The flag stays set until the next read that removes an entry.
- R10: After reset the buffer is empty, `rd_valid` is 0 and `overrun` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | One-cycle enable at 16x the baud rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_wlen | input | 2 | Data width code |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | Even parity, or stick value 0 |
| cfg_par_stick | input | 1 | Fixed parity value |
| cfg_fifo_en | input | 1 | Queued mode when 1, single entry when 0 |
| rd_en | input | 1 | Removes the oldest entry |
| rd_valid | output | 1 | Buffer holds at least one entry |
| rd_data | output | 8 | Oldest entry: data byte |
| rd_perr | output | 1 | Oldest entry: parity error |
| rd_ferr | output | 1 | Oldest entry: framing error |
| rd_brk | output | 1 | Oldest entry: break |
| overrun | output | 1 | Sticky: a character was lost |

## Verification
The assertions assume the line-control and buffer-mode inputs stay constant while a character is in flight. They also assume `os_tick` is a single-cycle pulse separated by idle cycles. The bench changes configuration only while the line is idle between frames and drives the tick from a fixed divider. Frames are sent with bit times that are exact multiples of sixteen ticks, so each centre sample falls well inside its bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OS_W   = 4;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_entry_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd,
  output logic rx_s,
  output logic rx_fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rxd;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_s    = sync_q;
  assign rx_fall = prev_q & ~sync_q;
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  logic       rx_fall,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       push,
  output rx_entry_t  entry
);
  localparam logic [OS_W-1:0] MID  = OS_W'(7);
  localparam logic [OS_W-1:0] LAST = OS_W'(15);

  rx_state_t         st_q, st_n;
  logic [OS_W-1:0]   cnt_q, cnt_n;
  logic [2:0]        idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              pbit_q, pbit_n;

  logic [2:0] last_idx;
  logic [2:0] shamt;
  logic       exp_par;

  assign last_idx = 3'd4 + {1'b0, wlen};
  assign shamt    = 3'd3 - {1'b0, wlen};

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    pbit_n = pbit_q;
    push   = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (rx_fall) begin
          st_n  = RX_START;
          cnt_n = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == MID) begin
            cnt_n = '0;
            if (!rx_s) begin
              st_n  = RX_DATA;
              idx_n = '0;
              sh_n  = '0;
            end else begin
              st_n = RX_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (tick) begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            sh_n  = {rx_s, sh_q[DATA_W-1:1]};
            idx_n = idx_q + 1'b1;
            if (idx_q == last_idx) st_n = par_en ? RX_PAR : RX_STOP;
          end
        end
      end
      RX_PAR: begin
        if (tick) begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            pbit_n = rx_s;
            st_n   = RX_STOP;
          end
        end
      end
      RX_STOP: begin
        if (tick) begin
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            push = 1'b1;
            st_n = RX_IDLE;
          end
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      pbit_q <= pbit_n;
    end
  end

  // unfilled shift positions are zero, so a full-width reduction covers the data bits
  always_comb begin
    if (par_stick) exp_par = ~par_even;
    else           exp_par = par_even ? ^sh_q : ~^sh_q;
  end

  always_comb begin
    entry.data = sh_q >> shamt;
    entry.perr = par_en & (pbit_q != exp_par);
    entry.ferr = ~rx_s;
    entry.brk  = (sh_q == '0) & (~par_en | ~pbit_q) & ~rx_s;
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_DATA && $past(st_q) == RX_START) |-> !$past(rx_s));

  assert_brk_framing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && entry.brk) |-> entry.ferr);

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && wlen == 2'd0) |-> (entry.data[7:5] == 3'b000));

  assert_no_perr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !par_en) |-> !entry.perr);
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_en,
  input  logic      push,
  input  rx_entry_t wr_entry,
  input  logic      pop,
  output logic      valid,
  output rx_entry_t head,
  output logic      overrun
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            ovr_q, ovr_n;
  logic [CW-1:0]   cap;
  logic            full, do_wr, do_rd;

  generate
    if (DEPTH > 1) begin : g_queue
      assign cap = fifo_en ? CW'(DEPTH) : CW'(1);
    end else begin : g_single
      assign cap = CW'(1);
    end
  endgenerate

  assign full  = (cnt_q >= cap);
  assign do_wr = push & ~full;
  assign do_rd = pop & (cnt_q != '0);

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = cnt_q;
    ovr_n = ovr_q;
    if (do_wr) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_wr && !do_rd)      cnt_n = cnt_q + 1'b1;
    else if (!do_wr && do_rd) cnt_n = cnt_q - 1'b1;
    if (push && full) ovr_n = 1'b1;
    else if (do_rd)   ovr_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
      ovr_q <= ovr_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_entry;
  end

  assign valid   = (cnt_q != '0);
  assign head    = mem[rp_q];
  assign overrun = ovr_q;

  assert_fill_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_single_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && $stable(fifo_en)) |-> (cnt_q <= CW'(1)));

  assert_ovr_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> overrun);

  assert_ovr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_stick,
  input  logic       cfg_fifo_en,
  input  logic       rd_en,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       overrun
);
  logic      rx_s, rx_fall, push;
  rx_entry_t entry, head;

  uart_rx_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rxd     (rxd),
    .rx_s    (rx_s),
    .rx_fall (rx_fall)
  );

  uart_rx_deser u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (os_tick),
    .rx_s      (rx_s),
    .rx_fall   (rx_fall),
    .wlen      (cfg_wlen),
    .par_en    (cfg_par_en),
    .par_even  (cfg_par_even),
    .par_stick (cfg_par_stick),
    .push      (push),
    .entry     (entry)
  );

  uart_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (cfg_fifo_en),
    .push     (push),
    .wr_entry (entry),
    .pop      (rd_en),
    .valid    (rd_valid),
    .head     (head),
    .overrun  (overrun)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign rd_brk  = head.brk;
endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;
  localparam int DEPTH    = 4;
  localparam int NVEC     = 13;

  // [17:16] wlen [15] par_en [14] even [13] stick [12:5] data [4] pbit [3] stop [2] perr [1] ferr [0] brk
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b0, 8'h2D, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b0, 8'h2D, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'h55, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b1, 8'h81, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'd3, 1'b0, 1'b0, 1'b0, 8'h7E, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'd2, 1'b0, 1'b0, 1'b0, 8'h40, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  logic       clk, rst_n, os_tick, rxd;
  logic [1:0] cfg_wlen;
  logic       cfg_par_en, cfg_par_even, cfg_par_stick, cfg_fifo_en, rd_en;
  logic       rd_valid, rd_perr, rd_ferr, rd_brk, overrun;
  logic [7:0] rd_data;
  int         div_cnt;
  int         total = 0;
  int         bad = 0;
  bit         done = 0;

  uart_frame_rx #(.DEPTH(DEPTH)) u_uart_frame_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_fifo_en(cfg_fifo_en), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .rd_brk(rd_brk), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= 0;
      os_tick <= 1'b0;
    end else begin
      div_cnt <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
      os_tick <= (div_cnt == TICK_DIV - 1);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    rxd = b;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [1:0] wl, input logic pen, input logic pbit,
                            input logic [7:0] d, input logic stop, input int idle_bits);
    send_bit(1'b0);
    for (int i = 0; i < 5 + int'(wl); i++) send_bit(d[i]);
    if (pen) send_bit(pbit);
    send_bit(stop);
    for (int i = 0; i < idle_bits; i++) send_bit(1'b1);
  endtask

  task automatic read_expect(input logic [10:0] exp, input string tag);
    @(negedge clk);
    check(rd_valid === 1'b1, {tag, " valid"}, 32'(rd_valid), 32'd1);
    check({rd_data, rd_perr, rd_ferr, rd_brk} === exp, tag,
          32'({rd_data, rd_perr, rd_ferr, rd_brk}), 32'(exp));
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic pen, input logic ev, input logic st);
    cfg_wlen = wl; cfg_par_en = pen; cfg_par_even = ev; cfg_par_stick = st;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rxd = 1'b1; rd_en = 1'b0; cfg_fifo_en = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check(rd_valid === 1'b0, "R10 valid after reset", 32'(rd_valid), 32'd0);
    check(overrun === 1'b0, "R10 overrun after reset", 32'(overrun), 32'd0);

    // table walk: R1 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] mask;
      mask = 8'hFF >> (3 - int'(VEC[v][17:16]));
      set_cfg(VEC[v][17:16], VEC[v][15], VEC[v][14], VEC[v][13]);
      send_frame(VEC[v][17:16], VEC[v][15], VEC[v][4], VEC[v][12:5], VEC[v][3], 2);
      read_expect({VEC[v][12:5] & mask, VEC[v][2:0]},
                  $sformatf("R1/R3/R4/R5/R6/R7 vector %0d", v));
    end

    // R2 short low pulse ignored
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rxd = 1'b0;
    repeat (5 * TICK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check(rd_valid === 1'b0, "R2 glitch stored nothing", 32'(rd_valid), 32'd0);

    // R6 next start directly after first stop bit
    send_frame(2'd3, 1'b0, 1'b0, 8'hC3, 1'b1, 0);
    send_frame(2'd3, 1'b0, 1'b0, 8'h5A, 1'b1, 2);
    cfg_fifo_en = 1'b1;
    @(negedge clk);
    // first frame sits alone in the single slot; second overran it
    read_expect({8'hC3, 3'b000}, "R6 first frame after one stop bit");
    cfg_fifo_en = 1'b1;
    send_frame(2'd3, 1'b0, 1'b0, 8'hC3, 1'b1, 0);
    send_frame(2'd3, 1'b0, 1'b0, 8'h5A, 1'b1, 2);
    read_expect({8'hC3, 3'b000}, "R6 back-to-back first");
    read_expect({8'h5A, 3'b000}, "R6 back-to-back second");
    cfg_fifo_en = 1'b0;

    // R7 held break yields one entry
    send_frame(2'd3, 1'b0, 1'b0, 8'h00, 1'b0, 0);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    send_bit(1'b1); send_bit(1'b1);
    read_expect({8'h00, 3'b011}, "R7 break entry");
    @(negedge clk);
    check(rd_valid === 1'b0, "R7 single break entry", 32'(rd_valid), 32'd0);

    // R8 R9 character mode: second char dropped, overrun raised
    send_frame(2'd3, 1'b0, 1'b0, 8'h11, 1'b1, 1);
    send_frame(2'd3, 1'b0, 1'b0, 8'h22, 1'b1, 1);
    @(negedge clk);
    check(overrun === 1'b1, "R9 overrun in character mode", 32'(overrun), 32'd1);
    read_expect({8'h11, 3'b000}, "R8 character mode keeps first");
    check(overrun === 1'b0, "R9 overrun cleared by read", 32'(overrun), 32'd0);
    check(rd_valid === 1'b0, "R8 character mode held one", 32'(rd_valid), 32'd0);

    // R8 R9 queued mode
    cfg_fifo_en = 1'b1;
    for (int k = 0; k <= DEPTH; k++)
      send_frame(2'd3, 1'b0, 1'b0, 8'(8'h30 + k), 1'b1, 1);
    @(negedge clk);
    check(overrun === 1'b1, "R9 overrun in queued mode", 32'(overrun), 32'd1);
    for (int k = 0; k < DEPTH; k++)
      read_expect({8'(8'h30 + k), 3'b000}, $sformatf("R8 queued order %0d", k));
    check(rd_valid === 1'b0, "R9 extra char discarded", 32'(rd_valid), 32'd0);
    check(overrun === 1'b0, "R9 overrun cleared in queued mode", 32'(overrun), 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule